// File: doc/BRIEF.md
# Multi-Mode Timer Time Base

This block is the time base of a general-purpose timer. A count-enable tick, supplied by an upstream clock selector, is divided by a programmable prescaler. Each prescaled tick advances a counter of parameterised width (16 or 32 bits). The counter runs against an auto-reload limit in one of three directions: up, down, or center-aligned, where it bounces between zero and the limit. Every wrap or turning point raises an update event. At an update event the preloaded prescaler and reload values are copied into the working (shadow) registers.

An update can also be forced, either by a software strobe or by a trigger edge from a slave controller. A forced update restarts the prescaler and the counter. A control bit chooses which causes may raise the update interrupt request. With the bit clear, all causes raise it. With the bit set, only counter overflow or underflow raises it. The update-event pulse itself is raised by every cause. The block has register write ports and plain control and status pins only, so none of its interfaces carries a data stream and no back-pressure applies.

Top module: `tmr_timebase`

## Requirements
- R1: After reset, the counter reads 0, `cnt_down` is 0 and `upd_evt` and `upd_irq` are low. The reset mode is up, the reset prescaler factor is 1, the reset reload value is all ones, and the interrupt-source bit is 0.
- R2: The counter advances once for every (P+1) cycles with `tick_en` high, where P is the active prescaler value. Cycles with `tick_en` low are not counted.
- R3: In up mode (`mode_wdata` = 0), the counter steps from 0 to the reload value A and then wraps to 0. The wrap raises an update event.
- R4: In down mode (`mode_wdata` = 1), the counter steps down from A to 0 and then reloads A. The reload raises an update event. `cnt_down` reads 1 in this mode.
- R5: In center-aligned mode (`mode_wdata` = 2), the counter counts up to A and then down to 0, over and over. An update event is raised when it leaves A and when it leaves 0 on the way down. `cnt_down` is 1 while it is descending.
- R6: `upd_evt` and `upd_irq` are single-cycle pulses. They are high in the cycle after the clock edge at which their cause was present.
- R7: A `sw_upd` strobe forces an update event. It clears the prescaler count and sets the counter to 0 (up and center-aligned modes) or to the new reload value (down mode). Center-aligned counting then restarts upward.
- R8: A `trig_edge` pulse has the same effect as `sw_upd`.
- R9: With the interrupt-source bit set to 1, `sw_upd` and `trig_edge` still pulse `upd_evt` but not `upd_irq`. Overflow and underflow pulse both outputs.
- R10: Prescaler and reload writes do not change counting until the next update event, which loads them.
- R11: With an active reload value of 0, the counter holds its value and raises no overflow events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-enable tick from the clock selector |
| sw_upd | input | 1 | Software update-generation strobe |
| trig_edge | input | 1 | Active trigger edge from the slave controller |
| psc_wr | input | 1 | Prescaler preload write strobe |
| psc_wdata | input | PSC_W | Prescaler value (division factor minus one) |
| arr_wr | input | 1 | Reload preload write strobe |
| arr_wdata | input | CNT_W | Reload value |
| mode_wr | input | 1 | Counting mode write strobe |
| mode_wdata | input | 2 | 0 up, 1 down, 2 or 3 center-aligned |
| urs_wr | input | 1 | Interrupt-source bit write strobe |
| urs_wdata | input | 1 | 1: only overflow/underflow raise the interrupt |
| cnt_q | output | CNT_W | Counter value |
| cnt_down | output | 1 | Counting direction, 1 = downward |
| upd_evt | output | 1 | Update event pulse |
| upd_irq | output | 1 | Update interrupt request pulse |

## Verification
The hardest states to reach are the turning points of center-aligned counting combined with a prescaler. There, the direction bit and the event count both depend on exactly how many prescaled ticks have elapsed. Also hard is the moment when a preloaded reload value takes over. The stimulus reaches both states deterministically. Each table vector first writes its mode, prescaler and reload values. It then forces an update, which loads the shadows and restarts from a known state. After that it applies a counted number of enable ticks chosen to stop just before, at, or just past a turning point. Directed tests then write a new reload value mid-run, and they interleave partial prescaler counts with a forced restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2
  } tmr_mode_e;

  function automatic tmr_mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'd0:    decode_mode = MODE_UP;
      2'd1:    decode_mode = MODE_DOWN;
      default: decode_mode = MODE_CENTER;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  input  logic             ld,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_sh;
  logic [PSC_W-1:0] psc_cnt;

  assign tick_o = tick_en && !clr && (psc_cnt == psc_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_sh  <= '0;
      psc_cnt <= '0;
    end else begin
      if (ld) psc_sh <= psc_pre;
      if (clr)          psc_cnt <= '0;
      else if (tick_o)  psc_cnt <= '0;
      else if (tick_en) psc_cnt <= psc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             ld,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] arr_pre,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] arr_sh,
  output logic             dir_dn,
  output logic             ovf
);
  logic at_top, at_zero, run;

  assign at_top  = (cnt >= arr_sh);
  assign at_zero = (cnt == '0);
  assign run     = tick && !force_upd && (arr_sh != '0);

  always_comb begin
    ovf = 1'b0;
    if (run) begin
      case (mode)
        MODE_UP:   ovf = at_top;
        MODE_DOWN: ovf = at_zero;
        default:   ovf = dir_dn ? at_zero : at_top;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      arr_sh <= '1;
      dir_dn <= 1'b0;
    end else begin
      if (ld) arr_sh <= arr_pre;
      if (force_upd) begin
        cnt    <= (mode == MODE_DOWN) ? arr_pre : '0;
        dir_dn <= (mode == MODE_DOWN);
      end else begin
        case (mode)
          MODE_UP: begin
            dir_dn <= 1'b0;
            if (run) cnt <= at_top ? '0 : cnt + 1'b1;
          end
          MODE_DOWN: begin
            dir_dn <= 1'b1;
            if (run) cnt <= at_zero ? arr_sh : cnt - 1'b1;
          end
          default: begin
            if (run) begin
              if (dir_dn) begin
                if (at_zero) begin
                  cnt    <= {{(CNT_W-1){1'b0}}, 1'b1};
                  dir_dn <= 1'b0;
                end else begin
                  cnt <= cnt - 1'b1;
                end
              end else begin
                if (at_top) begin
                  cnt    <= arr_sh - 1'b1;
                  dir_dn <= 1'b1;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_update_ctl.sv
module tmr_update_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic force_upd,
  input  logic ovf_only,
  output logic upd_now,
  output logic evt_q,
  output logic irq_q
);
  assign upd_now = ovf | force_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= upd_now;
      irq_q <= ovf | (force_upd & ~ovf_only);
    end
  end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sw_upd,
  input  logic             trig_edge,
  input  logic             psc_wr,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             arr_wr,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             urs_wr,
  input  logic             urs_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_down,
  output logic             upd_evt,
  output logic             upd_irq
);
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] arr_pre;
  logic [CNT_W-1:0] arr_sh;
  tmr_mode_e        mode_q;
  logic             urs_q;
  logic             force_upd, psc_tick, ovf, upd_now;

  assign force_upd = sw_upd | trig_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre <= '0;
      arr_pre <= '1;
      mode_q  <= MODE_UP;
      urs_q   <= 1'b0;
    end else begin
      if (psc_wr)  psc_pre <= psc_wdata;
      if (arr_wr)  arr_pre <= arr_wdata;
      if (mode_wr) mode_q  <= decode_mode(mode_wdata);
      if (urs_wr)  urs_q   <= urs_wdata;
    end
  end

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(force_upd),
    .ld(upd_now), .psc_pre(psc_pre), .tick_o(psc_tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(psc_tick), .force_upd(force_upd),
    .ld(upd_now), .mode(mode_q), .arr_pre(arr_pre), .cnt(cnt_q),
    .arr_sh(arr_sh), .dir_dn(cnt_down), .ovf(ovf)
  );

  tmr_update_ctl u_upd (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .force_upd(force_upd),
    .ovf_only(urs_q), .upd_now(upd_now), .evt_q(upd_evt), .irq_q(upd_irq)
  );
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_upd,
  input logic             trig_edge,
  input logic             psc_tick,
  input logic             ovf,
  input logic             urs_q,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] arr_sh,
  input logic [CNT_W-1:0] cnt_q,
  input logic             upd_evt,
  input logic             upd_irq
);
  // R6
  forced_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_upd || trig_edge) |=> upd_evt);

  // R6
  irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |-> upd_evt);

  // R9
  urs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (urs_q && !ovf) |=> !upd_irq);

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && psc_tick && arr_sh != '0 && cnt_q >= arr_sh
     && !sw_upd && !trig_edge) |=> (cnt_q == '0 && upd_evt));

  // R4
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && psc_tick && arr_sh != '0 && cnt_q == '0
     && !sw_upd && !trig_edge) |=> (cnt_q == $past(arr_sh) && upd_evt));

  // R11
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_sh == '0 && !sw_upd && !trig_edge) |=> ($stable(cnt_q) && !upd_evt));
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_upd(sw_upd), .trig_edge(trig_edge),
  .psc_tick(psc_tick), .ovf(ovf), .urs_q(urs_q), .mode_q(mode_q),
  .arr_sh(arr_sh), .cnt_q(cnt_q), .upd_evt(upd_evt), .upd_irq(upd_irq)
);

// File: tb/tmr_timebase_tb.sv
module tmr_timebase_tb;
  localparam int CNT_W = 16;
  localparam int PSC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 0, sw_upd = 0, trig_edge = 0;
  logic psc_wr = 0, arr_wr = 0, mode_wr = 0, urs_wr = 0, urs_wdata = 0;
  logic [PSC_W-1:0] psc_wdata = '0;
  logic [CNT_W-1:0] arr_wdata = '0;
  logic [1:0] mode_wdata = '0;
  logic [CNT_W-1:0] cnt_q;
  logic cnt_down, upd_evt, upd_irq;

  int n_chk = 0;
  int n_bad = 0;
  int ev_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sw_upd(sw_upd),
    .trig_edge(trig_edge), .psc_wr(psc_wr), .psc_wdata(psc_wdata),
    .arr_wr(arr_wr), .arr_wdata(arr_wdata), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .urs_wr(urs_wr), .urs_wdata(urs_wdata),
    .cnt_q(cnt_q), .cnt_down(cnt_down), .upd_evt(upd_evt), .upd_irq(upd_irq)
  );

  // mode, psc, arr, enabled ticks, expected count, expected dir, expected events
  localparam int NV = 10;
  localparam int VEC [NV][7] = '{
    '{0, 0, 4,  7, 2, 0, 1},
    '{0, 2, 3, 14, 0, 0, 1},
    '{1, 0, 5,  3, 2, 1, 0},
    '{1, 1, 2,  9, 1, 1, 1},
    '{2, 0, 3,  4, 2, 1, 1},
    '{2, 0, 3,  7, 1, 0, 2},
    '{2, 0, 3,  6, 0, 1, 1},
    '{2, 3, 2, 13, 1, 1, 1},
    '{0, 0, 0,  5, 0, 0, 0},
    '{1, 0, 0,  5, 0, 1, 0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int m, input int p, input int a);
    mode_wr = 1; mode_wdata = 2'(m);
    psc_wr = 1;  psc_wdata = PSC_W'(p);
    arr_wr = 1;  arr_wdata = CNT_W'(a);
    step();
    mode_wr = 0; psc_wr = 0; arr_wr = 0;
  endtask

  task automatic force_ug();
    sw_upd = 1;
    step();
    sw_upd = 0;
  endtask

  task automatic run(input int n);
    tick_en = 1;
    for (int i = 0; i < n; i++) begin
      step();
      if (upd_evt) ev_cnt++;
    end
    tick_en = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    check("R1 cnt", int'(cnt_q), 0);
    check("R1 dir", int'(cnt_down), 0);
    check("R1 evt", int'(upd_evt), 0);
    check("R1 irq", int'(upd_irq), 0);
    rst_n = 1;
    step();

    // R2 R3 R4 R5 R11 vector table
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v][0], VEC[v][1], VEC[v][2]);
      force_ug();
      ev_cnt = 0;
      run(VEC[v][3]);
      check($sformatf("R2/R3/R4/R5/R11 vec%0d cnt", v), int'(cnt_q), VEC[v][4]);
      check($sformatf("R4/R5 vec%0d dir", v), int'(cnt_down), VEC[v][5]);
      check($sformatf("R3/R4/R5/R11 vec%0d events", v), ev_cnt, VEC[v][6]);
    end

    // R2 ticks with tick_en low do not count
    cfg(0, 0, 9);
    force_ug();
    repeat (5) step();
    check("R2 idle no count", int'(cnt_q), 0);

    // R6 pulse timing for a forced update
    sw_upd = 1;
    step();
    sw_upd = 0;
    check("R6 evt after strobe", int'(upd_evt), 1);
    check("R6 irq after strobe", int'(upd_irq), 1);
    step();
    check("R6 evt single cycle", int'(upd_evt), 0);

    // R8 trigger restarts counter
    run(3);
    check("R8 pre cnt", int'(cnt_q), 3);
    trig_edge = 1;
    step();
    trig_edge = 0;
    check("R8 cnt restart", int'(cnt_q), 0);
    check("R8 evt", int'(upd_evt), 1);

    // R9 interrupt source selection
    urs_wr = 1; urs_wdata = 1;
    step();
    urs_wr = 0;
    sw_upd = 1;
    step();
    sw_upd = 0;
    check("R9 sw evt", int'(upd_evt), 1);
    check("R9 sw irq blocked", int'(upd_irq), 0);
    trig_edge = 1;
    step();
    trig_edge = 0;
    check("R9 trig irq blocked", int'(upd_irq), 0);
    cfg(0, 0, 1);
    force_ug();
    run(1);
    check("R9 no irq before wrap", int'(upd_irq), 0);
    run(1);
    check("R9 overflow evt", int'(upd_evt), 1);
    check("R9 overflow irq", int'(upd_irq), 1);
    urs_wr = 1; urs_wdata = 0;
    step();
    urs_wr = 0;

    // R10 reload preload
    cfg(0, 0, 4);
    force_ug();
    run(2);
    arr_wr = 1; arr_wdata = 9;
    step();
    arr_wr = 0;
    check("R10 write no immediate effect", int'(cnt_q), 2);
    run(3);
    check("R10 old limit used", int'(cnt_q), 0);
    run(7);
    check("R10 new limit used", int'(cnt_q), 7);

    // R7 forced update clears prescaler count
    cfg(0, 2, 9);
    force_ug();
    run(2);
    force_ug();
    run(1);
    check("R7 prescaler cleared", int'(cnt_q), 0);
    run(2);
    check("R7 count after restart", int'(cnt_q), 1);
    cfg(1, 0, 6);
    force_ug();
    check("R7 down restart", int'(cnt_q), 6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule